// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer and turns the programmed burst settings into a stream of column addresses. A mode-register load strobe captures a 12-bit mode word plus the bank bits. The block checks the word and keeps the burst length, burst order, CAS latency and write-mode setting it holds. A reserved encoding is refused and raises an error flag.

A burst start strobe carries the first column and the direction. From the next cycle the block presents one column per beat and moves to the next beat on each cycle that the advance input is high. A stop input, or a new start, ends the burst early. The decoded CAS latency is offered to the read data path.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: After reset no burst is active, the stored settings are length 1, sequential order, CAS latency 3 and burst writes, and the error flag is low.
- R2: Mode word bits [2:0] set the burst length: 000→1, 001→2, 010→4, 011→8, 111→full page.
- R3: With bit 3 = 0 (sequential), beat k of a length-L burst has low log2(L) bits equal to (start + k) mod L. The upper column bits stay equal to those of the start column.
- R4: With bit 3 = 1 (interleaved), beat k has low log2(L) bits equal to the start bits XOR k. The upper bits stay fixed.
- R5: Mode word bits [6:4] = 010 or 011 set a CAS latency of 2 or 3, and `cas_lat_o` presents it from the cycle after the load.
- R6: A load is reserved, and sets `mr_err_o` high in the next cycle while every stored setting stays unchanged, when any of these holds: length code 100/101/110, length 111 with interleaved order, a latency code other than 010/011, nonzero bits [8:7] or [11:10], or a nonzero bank field. A legal load clears `mr_err_o`.
- R7: With bit 9 = 1, a write burst has one beat and a read burst keeps the programmed length.
- R8: A full-page burst wraps modulo 2048 columns, never raises `last_o`, and runs until it is stopped or restarted.
- R9: The first beat appears in the cycle after `start_i`. The column moves on only in cycles where `advance_i` is high, and holds otherwise.
- R10: `last_o` is high on the final beat of a finite burst. Advancing on that beat ends the burst in the next cycle.
- R11: `stop_i` ends a burst in the next cycle. `start_i` always begins a new burst, even during a burst or when `stop_i` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mr_load_i | input | 1 | Mode-register load strobe |
| mr_word_i | input | 12 | Mode word |
| mr_bank_i | input | 2 | Bank field of the mode load, must be zero |
| start_i | input | 1 | Burst start strobe |
| start_write_i | input | 1 | Direction of the starting burst, 1 = write |
| start_col_i | input | 11 | First column of the burst |
| advance_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the current burst |
| col_o | output | 11 | Column of the current beat |
| beat_valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Current beat is the final one |
| cas_lat_o | output | 3 | Stored CAS latency (2 or 3) |
| mr_err_o | output | 1 | The last mode load was refused |

## Verification
The bench builds the block with its default 11-bit column and 12-bit mode word. With these widths a full-page burst started near column 2047 crosses the wrap to column 0 within a few beats. Every mode-word field position in use can be driven, including the upper reserved bits [11:10]. A behavioural model tracks the stored settings and the burst state. It is compared every cycle while bursts of each length and both orders run with gapped advance, restarts, stops and refused loads.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef struct packed {
    logic       full;
    logic [1:0] len_log;
    logic       ilv;
    logic       wsingle;
    logic [2:0] cas;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{full: 1'b0, len_log: 2'd0, ilv: 1'b0,
                                       wsingle: 1'b0, cas: 3'd3};
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
#(
  parameter int MR_W = 12,
  parameter int BA_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MR_W-1:0] word_i,
  input  logic [BA_W-1:0] bank_i,
  output burst_cfg_t      cfg_o,
  output logic            err_o
);
  localparam int WM_BIT = 9;

  burst_cfg_t cfg_q, cfg_d;
  logic       err_q, bad;

  always_comb begin
    cfg_d         = cfg_q;
    bad           = 1'b0;
    cfg_d.ilv     = word_i[3];
    cfg_d.wsingle = word_i[WM_BIT];
    cfg_d.full    = 1'b0;
    cfg_d.len_log = 2'd0;
    unique case (word_i[2:0])
      3'b000:  cfg_d.len_log = 2'd0;
      3'b001:  cfg_d.len_log = 2'd1;
      3'b010:  cfg_d.len_log = 2'd2;
      3'b011:  cfg_d.len_log = 2'd3;
      3'b111: begin
        cfg_d.full = 1'b1;
        if (word_i[3]) bad = 1'b1;  // full page has no interleaved form
      end
      default: bad = 1'b1;
    endcase
    if (word_i[6:4] == 3'd2 || word_i[6:4] == 3'd3) cfg_d.cas = word_i[6:4];
    else bad = 1'b1;
    if (word_i[8:7] != '0) bad = 1'b1;
    if (word_i[MR_W-1:WM_BIT+1] != '0) bad = 1'b1;
    if (bank_i != '0) bad = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else if (load_i) begin
      err_q <= bad;
      if (!bad) cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  assert_reserved_keeps_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && bad |=> $stable(cfg_q) && err_o);
  assert_cas_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.cas == 3'd2 || cfg_q.cas == 3'd3);
  assert_full_only_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q.full && cfg_q.ilv));
endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
  import burst_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  burst_cfg_t       cfg_i,
  input  logic             start_i,
  input  logic             start_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             advance_i,
  input  logic             stop_i,
  output logic             valid_o,
  output logic             last_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic             valid_q, full_q, ilv_q;
  logic [COL_W-1:0] cnt_q, base_q, mask_q, mask_n;
  logic             single_n, full_n;
  logic [1:0]       len_log_n;

  always_comb begin
    single_n  = start_write_i && cfg_i.wsingle;
    full_n    = cfg_i.full && !single_n;
    len_log_n = single_n ? 2'd0 : cfg_i.len_log;
    mask_n    = full_n ? '1 : (ONE << len_log_n) - ONE;
  end

  assign last_o = valid_q && !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      full_q  <= full_n;
      ilv_q   <= cfg_i.ilv;
      cnt_q   <= '0;
      base_q  <= start_col_i;
      mask_q  <= mask_n;
    end else if (stop_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && advance_i) begin
      if (last_o) valid_q <= 1'b0;
      else        cnt_q   <= cnt_q + ONE;
    end
  end

  assign valid_o = valid_q;
  assign ilv_o   = ilv_q;
  assign base_o  = base_q;
  assign cnt_o   = cnt_q;
  assign mask_o  = mask_q;

  assert_last_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && advance_i && !start_i && !stop_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !advance_i && !start_i && !stop_i |=> valid_o && $stable(cnt_q));
  assert_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o);
  assert_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && cnt_q == '0);
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 11
) (
  input  logic             ilv_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col, ilv_col;

  assign seq_col = (base_i & ~mask_i) | ((base_i + cnt_i) & mask_i);
  assign ilv_col = base_i ^ (cnt_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int MR_W  = 12,
  parameter int BA_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mr_load_i,
  input  logic [MR_W-1:0]  mr_word_i,
  input  logic [BA_W-1:0]  mr_bank_i,
  input  logic             start_i,
  input  logic             start_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             advance_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o,
  output logic [2:0]       cas_lat_o,
  output logic             mr_err_o
);
  burst_cfg_t       cfg;
  logic             ilv;
  logic [COL_W-1:0] base, cnt, mask;

  burst_mode_reg #(.MR_W(MR_W), .BA_W(BA_W)) i_mode (
    .clk_i, .rst_ni, .load_i(mr_load_i), .word_i(mr_word_i), .bank_i(mr_bank_i),
    .cfg_o(cfg), .err_o(mr_err_o)
  );

  burst_beat_ctl #(.COL_W(COL_W)) i_beat (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_i, .start_write_i, .start_col_i,
    .advance_i, .stop_i, .valid_o(beat_valid_o), .last_o, .ilv_o(ilv),
    .base_o(base), .cnt_o(cnt), .mask_o(mask)
  );

  burst_col_map #(.COL_W(COL_W)) i_map (
    .ilv_i(ilv), .base_i(base), .cnt_i(cnt), .mask_i(mask), .col_o
  );

  assign cas_lat_o = cfg.cas;

  assert_upper_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && advance_i && !last_o && !start_i && !stop_i
    |=> ((col_o ^ $past(col_o)) & ~mask) == '0);
  assert_last_in_burst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);
endmodule

// File: tb/test_sdram_burst_addr_gen.sv
module test_sdram_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        mr_load_i = 0, start_i = 0, start_write_i = 0, advance_i = 0, stop_i = 0;
  logic [11:0] mr_word_i = '0;
  logic [1:0]  mr_bank_i = '0;
  logic [10:0] start_col_i = '0;
  logic [10:0] col_o;
  logic        beat_valid_o, last_o, mr_err_o;
  logic [2:0]  cas_lat_o;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state
  int  m_bl, m_cl; bit m_ilv, m_ws, m_err;
  bit  b_act, b_ilv; int b_len, b_start, b_beat;

  sdram_burst_addr_gen i_sdram_burst_addr_gen (.*, .clk_i(clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mode_ok(logic [11:0] w, logic [1:0] b);
    int blc = w[2:0];
    if (b != 0 || w[11:10] != 0 || w[8:7] != 0) return 0;
    if (!(w[6:4] inside {3'd2, 3'd3})) return 0;
    if (blc inside {4, 5, 6}) return 0;
    if (blc == 7 && w[3]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_bl = 1; m_cl = 3; m_ilv = 0; m_ws = 0; m_err = 0; b_act = 0;
    end else begin
      if (start_i) begin
        b_act = 1; b_start = start_col_i; b_beat = 0; b_ilv = m_ilv;
        b_len = (start_write_i && m_ws) ? 1 : m_bl;
      end else if (stop_i) b_act = 0;
      else if (b_act && advance_i) begin
        if (b_len != 0 && b_beat == b_len - 1) b_act = 0;
        else b_beat++;
      end
      if (mr_load_i) begin
        if (mode_ok(mr_word_i, mr_bank_i)) begin
          m_err = 0; m_ilv = mr_word_i[3]; m_ws = mr_word_i[9]; m_cl = mr_word_i[6:4];
          m_bl = (mr_word_i[2:0] == 7) ? 0 : (1 << mr_word_i[2:0]);
        end else m_err = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    int exp_col;
    chk("valid", beat_valid_o, b_act);
    chk("cas", cas_lat_o, m_cl);
    chk("err", mr_err_o, m_err);
    if (b_act) begin
      if (b_len == 0) exp_col = (b_start + b_beat) % 2048;
      else if (b_ilv) exp_col = b_start ^ b_beat;
      else exp_col = (b_start / b_len) * b_len + ((b_start % b_len) + b_beat) % b_len;
      chk("col", col_o, exp_col);
      chk("last", last_o, (b_len != 0 && b_beat == b_len - 1));
    end else chk("last", last_o, 0);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      mr_load_i = 0; start_i = 0; stop_i = 0; advance_i = 0;
    end
  endtask

  task automatic load(logic [11:0] w, logic [1:0] b = 0);
    @(negedge clk);
    mr_load_i = 1; mr_word_i = w; mr_bank_i = b; start_i = 0; stop_i = 0;
    @(negedge clk); mr_load_i = 0;
  endtask

  task automatic start(int col, bit wr);
    @(negedge clk);
    start_i = 1; start_col_i = col; start_write_i = wr; stop_i = 0; advance_i = 0;
    @(negedge clk); start_i = 0;
  endtask

  // advance pattern: bit i of pat for cycle i
  task automatic run(int n, int pat = -1);
    for (int i = 0; i < n; i++) begin
      advance_i = pat[i % 32];
      @(negedge clk);
    end
    advance_i = 0;
  endtask

  function automatic logic [11:0] mw(int bl, bit ilv, int cl, bit ws);
    return 12'(bl | (ilv << 3) | (cl << 4) | (ws << 9));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    tag = "R1"; idle(2);
    start(12'h1A6, 0); run(3);           // R1: reset length 1
    tag = "R3"; load(mw(2, 0, 3, 0));  start(12'h1A6, 0); run(6);
    tag = "R4"; load(mw(3, 1, 3, 0));  start(12'h0F3, 1); run(10);
    tag = "R9"; load(mw(1, 0, 2, 0));  start(12'h3FF, 0); run(8, 32'b1001001);
    tag = "R5"; idle(2); load(mw(0, 0, 3, 0)); idle(1); load(mw(0, 0, 2, 0)); idle(1);
    tag = "R2"; load(mw(1, 1, 3, 0)); start(12'h555, 0); run(4);
    tag = "R6";
    load(mw(5, 0, 3, 0)); idle(1);
    load(mw(7, 1, 3, 0)); idle(1);
    load(mw(2, 0, 4, 0)); idle(1);
    load(mw(2, 0, 3, 0) | 12'h080); idle(1);
    load(mw(2, 0, 3, 0) | 12'h800); idle(1);
    load(mw(2, 0, 3, 0), 2'd1); idle(1);
    start(12'h10E, 0); run(4);          // still length 2 interleaved
    load(mw(3, 0, 3, 0)); idle(1);      // R6 legal load clears
    tag = "R7"; load(mw(3, 0, 2, 1));
    start(12'h042, 1); run(3);
    start(12'h042, 0); run(10);
    tag = "R8"; load(mw(7, 0, 3, 0));
    start(12'h7FD, 0); run(7, 32'b1110111);
    idle(3);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0; idle(2);
    tag = "R11"; load(mw(2, 0, 3, 0));
    start(12'h208, 1); run(2);
    start(12'h30B, 0); run(1);
    @(negedge clk); stop_i = 1; start_i = 1; start_col_i = 12'h111; @(negedge clk);
    start_i = 0; stop_i = 0; run(2);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0; idle(2);
    tag = "R10"; start(12'h0C1, 0); run(6, 32'b110111);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule